// File: doc/BRIEF.md
# Two-Way Tagged Branch Target Buffer

This block remembers where taken branches went, so that the fetch stage can redirect on the cycle a known branch is fetched. A fetch address presented on the lookup pins is split into a set index and a tag. The two entries of the selected set are compared against the tag, and a match returns the stored destination. Without a match the block returns the sequential address, fetch PC plus four, so fetch can use the output directly in either case.

The execute stage reports each resolved branch on the update pins: the branch address, the destination it computed and whether the branch was taken. Only taken branches are written. A branch already held in the set has its destination replaced in place. A new branch fills an empty entry if the set has one, and otherwise replaces the entry that was written or refreshed less recently. An update is sampled on the rising clock edge. There is no back-pressure: an update presented with its enable high is always accepted in that cycle, and the lookup side is purely combinational.

Top module: `tgt_buffer2w`

## Requirements
- R1: After reset every entry is empty: every lookup misses until a taken update is written.
- R2: A lookup hits when an entry of the set chosen by `lk_pc[SET_LG+1:2]` is valid and its tag equals `lk_pc[PC_W-1:SET_LG+2]`. On a hit `lk_target` is the full stored destination.
- R3: On a miss `lk_hit` is 0 and `lk_target` equals `lk_pc + 4`, modulo 2^PC_W.
- R4: A taken update is visible to lookups from the cycle after its clock edge. A lookup in the same cycle as the update sees the previous contents.
- R5: An update with `upd_taken` low, or with `upd_en` low, changes no entry and no replacement state.
- R6: A taken update for a branch already held in its set overwrites that entry's destination. The branch is never held twice, and the other entry of the set is kept.
- R7: While a set holds fewer than two branches, a new taken branch fills an empty entry and evicts nothing.
- R8: When both entries of a set are valid, a new taken branch replaces the entry whose most recent allocation or refresh is older. Lookups do not change recency.
- R9: A branch whose index matches an entry but whose tag differs misses. It does not pick up the other branch's destination.
- R10: Bits 1:0 of a PC are part of neither the index nor the tag, so addresses in the same 4-byte word share one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | PC_W | Fetch address to look up |
| lk_hit | output | 1 | A stored destination was found |
| lk_target | output | PC_W | Predicted next fetch address |
| upd_en | input | 1 | A resolved branch is presented |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_target | input | PC_W | Destination computed for the branch |
| upd_taken | input | 1 | The branch was taken |

## Verification
The bench aims at the cases where a set is contested. It fills a set with two branches, then refreshes one and brings in a third. A design that tracked recency by allocation alone, or updated recency on lookups, would evict the wrong branch. It aliases a branch onto an occupied index with a different tag. A missing or truncated tag compare would return the other branch's destination. It also checks a lookup in the same cycle as the update and sends not-taken updates for held branches. This catches a bypass that is not allowed, a write that lands one cycle late, and a destination that a not-taken outcome wrongly overwrites. Long mixed runs over four tags in four sets are compared against a behavioural model on every clock.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;
  localparam int unsigned WAYS = 2;
  typedef logic way_t;

  // Refresh a matching way first, then fill an empty way, else evict the LRU way.
  function automatic way_t choose_way(input logic [WAYS-1:0] hit,
                                      input logic [WAYS-1:0] valid,
                                      input way_t lru);
    if (hit[1])        return 1'b1;
    else if (hit[0])   return 1'b0;
    else if (!valid[0]) return 1'b0;
    else if (!valid[1]) return 1'b1;
    else               return lru;
  endfunction
endpackage

// File: rtl/tbuf_way_store.sv
module tbuf_way_store #(
  parameter int unsigned SET_LG = 4,
  parameter int unsigned TAG_W  = 26,
  parameter int unsigned PC_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SET_LG-1:0] rd_a_idx,
  output logic              rd_a_valid,
  output logic [TAG_W-1:0]  rd_a_tag,
  output logic [PC_W-1:0]   rd_a_target,
  input  logic [SET_LG-1:0] rd_b_idx,
  output logic              rd_b_valid,
  output logic [TAG_W-1:0]  rd_b_tag,
  input  logic              we,
  input  logic [SET_LG-1:0] wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [PC_W-1:0]   wr_target
);
  localparam int unsigned SETS = 1 << SET_LG;

  logic [SETS-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [PC_W-1:0]  tgt_q [SETS];

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (we) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_target;
    end
  end

  assign rd_a_valid  = valid_q[rd_a_idx];
  assign rd_a_tag    = tag_q[rd_a_idx];
  assign rd_a_target = tgt_q[rd_a_idx];
  assign rd_b_valid  = valid_q[rd_b_idx];
  assign rd_b_tag    = tag_q[rd_b_idx];

  // R5: valid bits move only when the update path asserts a write
  p_quiet_valid_r5: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(valid_q));
  // R1: the cycle after reset every entry is empty
  p_reset_empty_r1: assert property (@(posedge clk)
    rst |=> (valid_q == '0));
endmodule

// File: rtl/tbuf_lru.sv
module tbuf_lru #(
  parameter int unsigned SET_LG = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              touch,
  input  logic [SET_LG-1:0] touch_idx,
  input  tbuf_pkg::way_t    touch_way,
  input  logic [SET_LG-1:0] rd_idx,
  output tbuf_pkg::way_t    victim
);
  localparam int unsigned SETS = 1 << SET_LG;

  // one bit per set naming the least recently written way
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk) begin
    if (rst) lru_q <= '0;
    else if (touch) lru_q[touch_idx] <= ~touch_way;
  end

  assign victim = lru_q[rd_idx];

  // R5: recency state frozen without a taken update
  p_quiet_lru_r5: assert property (@(posedge clk) disable iff (rst)
    !touch |=> $stable(lru_q));
  // R8: the way just written is never the next victim of its set
  p_mru_not_victim_r8: assert property (@(posedge clk) disable iff (rst)
    touch |=> (lru_q[$past(touch_idx)] != $past(touch_way)));
endmodule

// File: rtl/tgt_buffer2w.sv
module tgt_buffer2w #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned SET_LG = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic [PC_W-1:0] lk_target,
  input  logic            upd_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_taken
);
  import tbuf_pkg::*;

  localparam int unsigned TAG_W = PC_W - SET_LG - 2;
  localparam int unsigned IDX_LO = 2;
  localparam int unsigned TAG_LO = SET_LG + 2;

  logic [SET_LG-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0]  lk_tag, up_tag;

  assign lk_idx = lk_pc[TAG_LO-1:IDX_LO];
  assign lk_tag = lk_pc[PC_W-1:TAG_LO];
  assign up_idx = upd_pc[TAG_LO-1:IDX_LO];
  assign up_tag = upd_pc[PC_W-1:TAG_LO];

  logic [WAYS-1:0] lk_valid, lk_match, up_valid, up_match, way_we;
  logic [TAG_W-1:0] lk_tag_rd [WAYS];
  logic [TAG_W-1:0] up_tag_rd [WAYS];
  logic [PC_W-1:0]  lk_tgt_rd [WAYS];
  logic             write_go;
  way_t             lru_victim, fill_way;

  assign write_go = upd_en && upd_taken;
  assign fill_way = choose_way(up_match, up_valid, lru_victim);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tbuf_way_store #(.SET_LG(SET_LG), .TAG_W(TAG_W), .PC_W(PC_W)) i_store (
      .clk        (clk),
      .rst        (rst),
      .rd_a_idx   (lk_idx),
      .rd_a_valid (lk_valid[w]),
      .rd_a_tag   (lk_tag_rd[w]),
      .rd_a_target(lk_tgt_rd[w]),
      .rd_b_idx   (up_idx),
      .rd_b_valid (up_valid[w]),
      .rd_b_tag   (up_tag_rd[w]),
      .we         (way_we[w]),
      .wr_idx     (up_idx),
      .wr_tag     (up_tag),
      .wr_target  (upd_target)
    );
    assign lk_match[w] = lk_valid[w] && (lk_tag_rd[w] == lk_tag);
    assign up_match[w] = up_valid[w] && (up_tag_rd[w] == up_tag);
    assign way_we[w]   = write_go && (fill_way == way_t'(w));
  end

  tbuf_lru #(.SET_LG(SET_LG)) i_lru (
    .clk      (clk),
    .rst      (rst),
    .touch    (write_go),
    .touch_idx(up_idx),
    .touch_way(fill_way),
    .rd_idx   (up_idx),
    .victim   (lru_victim)
  );

  always_comb begin
    lk_hit    = |lk_match;
    lk_target = lk_pc + PC_W'(4);
    if (lk_match[1])      lk_target = lk_tgt_rd[1];
    else if (lk_match[0]) lk_target = lk_tgt_rd[0];
  end

  // R6: a branch is never held in both ways of a set
  p_single_copy_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(lk_match) <= 1);
  // R4: a taken update is seen by a lookup of the same word one cycle later
  p_visible_next_r4: assert property (@(posedge clk) disable iff (rst)
    write_go |=> ((lk_pc[PC_W-1:2] != $past(upd_pc[PC_W-1:2])) ||
                  (lk_hit && lk_target == $past(upd_target))));
  // R3: a miss always yields the next sequential word
  p_miss_seq_r3: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_target == lk_pc + PC_W'(4)));
endmodule

// File: tb/test_tgt_buffer2w.sv
module test_tgt_buffer2w;
  localparam int PW = 32;
  localparam int SL = 4;
  localparam int NS = 1 << SL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PW-1:0] lk_pc = '0;
  logic lk_hit;
  logic [PW-1:0] lk_target;
  logic upd_en = 1'b0;
  logic [PW-1:0] upd_pc = '0;
  logic [PW-1:0] upd_target = '0;
  logic upd_taken = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tgt_buffer2w #(.PC_W(PW), .SET_LG(SL)) i_tgt_buffer2w (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_target(lk_target),
    .upd_en(upd_en), .upd_pc(upd_pc), .upd_target(upd_target), .upd_taken(upd_taken)
  );

  // behavioural model: per set, slot 0 = most recently written, slot 1 = older
  int            m_n   [NS];
  logic [PW-1:0] m_pc  [NS][2];
  logic [PW-1:0] m_tg  [NS][2];

  function automatic int set_of(input logic [PW-1:0] pc);
    return int'(pc[SL+1:2]);
  endfunction

  function automatic bit same_word(input logic [PW-1:0] a, input logic [PW-1:0] b);
    return a[PW-1:2] == b[PW-1:2];
  endfunction

  task automatic model_lookup(input logic [PW-1:0] pc, output bit hit, output logic [PW-1:0] tg);
    int s = set_of(pc);
    hit = 0;
    tg = pc + 4;
    for (int k = 0; k < m_n[s]; k++)
      if (same_word(m_pc[s][k], pc)) begin hit = 1; tg = m_tg[s][k]; end
  endtask

  task automatic model_write(input logic [PW-1:0] pc, input logic [PW-1:0] tg);
    int s = set_of(pc);
    if (m_n[s] > 0 && same_word(m_pc[s][0], pc)) begin
      m_tg[s][0] = tg;
    end else if (m_n[s] > 1 && same_word(m_pc[s][1], pc)) begin
      m_pc[s][1] = m_pc[s][0]; m_tg[s][1] = m_tg[s][0];
      m_pc[s][0] = pc; m_tg[s][0] = tg;
    end else begin
      m_pc[s][1] = m_pc[s][0]; m_tg[s][1] = m_tg[s][0];
      m_pc[s][0] = pc; m_tg[s][0] = tg;
      if (m_n[s] < 2) m_n[s]++;
    end
  endtask

  task automatic check(input string req, input bit ehit, input logic [PW-1:0] etg);
    checks++;
    if (lk_hit !== ehit || lk_target !== etg) begin
      errors++;
      $display("FAIL %s pc=%h hit=%0b target=%h expected hit=%0b target=%h",
               req, lk_pc, lk_hit, lk_target, ehit, etg);
    end
  endtask

  // one clock: drive at negedge, compare before the edge, advance model at the edge
  task automatic cyc(input logic [PW-1:0] lpc, input bit ue, input logic [PW-1:0] upc,
                     input logic [PW-1:0] utg, input bit ut, input string req);
    bit eh;
    logic [PW-1:0] et;
    lk_pc = lpc; upd_en = ue; upd_pc = upc; upd_target = utg; upd_taken = ut;
    #2;
    model_lookup(lpc, eh, et);
    if (req == "") check(eh ? "R2" : "R3", eh, et);
    else check(req, eh, et);
    @(posedge clk);
    if (ue && ut) model_write(upc, utg);
    @(negedge clk);
  endtask

  task automatic look(input logic [PW-1:0] lpc, input string req);
    cyc(lpc, 0, '0, '0, 0, req);
  endtask

  task automatic expect_now(input logic [PW-1:0] lpc, input bit eh, input logic [PW-1:0] et,
                            input string req);
    lk_pc = lpc; upd_en = 0; upd_taken = 0;
    #2;
    check(req, eh, et);
    @(negedge clk);
  endtask

  localparam logic [PW-1:0] PA = 32'h0000_1010;
  localparam logic [PW-1:0] PB = 32'h0000_1020;
  localparam logic [PW-1:0] PC2 = 32'h0000_2010;
  localparam logic [PW-1:0] PD = 32'h0000_3010;

  initial begin
    for (int s = 0; s < NS; s++) m_n[s] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: nothing held after reset
    look(PA, "R1");
    look(PB, "R1");
    look(32'hFFFF_FFFC, "R1");
    // R4: same-cycle lookup sees old contents, next cycle sees the write
    cyc(PA, 1, PA, 32'h0000_8000, 1, "R4");
    expect_now(PA, 1, 32'h0000_8000, "R4");
    // R5: not-taken updates leave contents alone
    cyc(PB, 1, PB, 32'h0000_9000, 0, "R5");
    expect_now(PB, 0, PB + 4, "R5");
    cyc(PA, 1, PA, 32'h0000_7000, 0, "R5");
    expect_now(PA, 1, 32'h0000_8000, "R5");
    cyc(PA, 0, PB, 32'h0000_9000, 1, "R5");
    expect_now(PB, 0, PB + 4, "R5");
    // R9: alias in same set with another tag misses
    expect_now(PC2, 0, PC2 + 4, "R9");
    // R7: second branch fills the free way, first survives
    cyc(PC2, 1, PC2, 32'h0000_A000, 1, "R7");
    expect_now(PC2, 1, 32'h0000_A000, "R7");
    expect_now(PA, 1, 32'h0000_8000, "R7");
    // R6: refresh A in place; C kept
    cyc(PA, 1, PA, 32'h0000_8800, 1, "R6");
    expect_now(PA, 1, 32'h0000_8800, "R6");
    expect_now(PC2, 1, 32'h0000_A000, "R6");
    // R8: A refreshed last, C is older, lookups on C do not help it
    look(PC2, "R8");
    cyc(PD, 1, PD, 32'h0000_B000, 1, "R8");
    expect_now(PD, 1, 32'h0000_B000, "R8");
    expect_now(PC2, 0, PC2 + 4, "R8");
    expect_now(PA, 1, 32'h0000_8800, "R8");
    // R10: low address bits share the word's entry
    expect_now(PA | 32'h3, 1, 32'h0000_8800, "R10");
    expect_now(PD | 32'h2, 1, 32'h0000_B000, "R10");
    // mixed traffic, compared every clock
    for (int n = 0; n < 4000; n++) begin
      logic [PW-1:0] a, b, t;
      a = (PW'($urandom_range(0, 3)) << (SL + 2)) | (PW'($urandom_range(0, 3)) << 2)
          | PW'($urandom_range(0, 3)) | 32'h0040_0000;
      b = (PW'($urandom_range(0, 3)) << (SL + 2)) | (PW'($urandom_range(0, 3)) << 2)
          | 32'h0040_0000;
      t = $urandom;
      cyc(a, $urandom_range(0, 2) != 0, b, t, $urandom_range(0, 3) != 0, "");
    end
    // R1: reset empties the table again
    rst = 1;
    @(negedge clk);
    rst = 0;
    for (int s = 0; s < NS; s++) m_n[s] = 0;
    expect_now(PA, 0, PA + 4, "R1");
    expect_now(32'h0040_0000, 0, 32'h0040_0004, "R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule